// File: doc/BRIEF.md
# UART FIFO Trigger and DMA-Request Controller

This block holds the FIFO control logic of one UART channel. It keeps a receive queue and a transmit queue, each of `DEPTH` (default 64) bytes. It also holds a write-only FIFO control byte that the host programs through the register port. From the fill level of each queue it derives four outputs: two active-low DMA request lines (`rxrdy_n`, `txrdy_n`), a received-data-available interrupt and a transmit interrupt. A character-timeout pulse comes in from the external receive timer.

The control byte uses these bit positions:

| Bit(s) | Function |
|--------|----------|
| 0 | FIFO mode enable |
| 1 | Receive-queue clear |
| 2 | Transmit-queue clear |
| 3 | DMA signalling mode |
| 5:4 | Transmit threshold select |
| 7:6 | Receive trigger select |

With FIFO mode off, each direction acts as a single-byte holding register. DMA signalling mode 0 requests one transfer at a time. Mode 1 requests bursts: a request, once raised, is held until the queue is drained (receive) or filled (transmit). The two clear bits do not stay set after the write. The transmit clear discards only queued bytes; the serial shifter outside the block keeps whatever it has already taken.

Top module: `uart_fifo_dma_ctl`

## Requirements
- R1: After master reset, both counts are 0, `rxrdy_n` is 1, `txrdy_n` is 0, FIFO mode is off, DMA mode is 0, and both trigger selects are 00.
- R2: With FIFO mode off, each direction holds at most one byte. A push into a full holding register, or into a full queue, is dropped and leaves the stored byte unchanged.
- R3: In DMA mode 0, or whenever FIFO mode is off, `rxrdy_n` is 0 exactly while the receive count is non-zero.
- R4: In DMA mode 0, or whenever FIFO mode is off, `txrdy_n` is 0 exactly while the transmit count is zero.
- R5: In DMA mode 1 (bit 3 = 1 and bit 0 = 1), `rxrdy_n` falls when the receive count reaches the trigger level or a timeout pulse arrives with data held. It then stays 0 until the receive count returns to zero.
- R6: In DMA mode 1, `txrdy_n` falls when the free transmit slots (`DEPTH` minus count) exceed the threshold. It then stays 0 until the transmit queue is completely full.
- R7: Bits 7:6 select the receive trigger level: 00 = 8, 01 = 16, 10 = 56, 11 = 60. `rx_int` is high while `rx_int_en` is 1 and the count is at or above the level. With FIFO mode off, the level is 1.
- R8: Bits 5:4 select the transmit threshold: 00 = 8, 01 = 16, 10 = 32, 11 = 56. `tx_int` is high while `tx_int_en` is 1 and the free slots exceed the threshold. With FIFO mode off, `tx_int` is high while the holding register is empty.
- R9: `rx_int` stays 0 while `rx_int_en` is 0, whatever the receive count.
- R10: A control write with bits 0 and 2 set empties the transmit queue and leaves the receive queue untouched. The clear bit is not retained. With FIFO mode off and unchanged, bit 2 has no effect.
- R11: A control write with bits 0 and 1 set empties the receive queue and leaves the transmit queue untouched. The clear bit is not retained.
- R12: With FIFO mode off, bit 3 has no effect on `rxrdy_n` or `txrdy_n`.
- R13: Each queue delivers bytes in the order they were pushed. `host_rdata` and `tx_pdata` present the oldest byte.
- R14: A control write that changes bit 0 empties both queues.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low master reset |
| fcr_we | input | 1 | Control byte write strobe |
| fcr_wdata | input | 8 | Control byte value |
| rx_int_en | input | 1 | Receive-data interrupt enable |
| tx_int_en | input | 1 | Transmit interrupt enable |
| host_wr | input | 1 | Host writes a transmit byte |
| host_wdata | input | DW | Transmit byte from host |
| host_rd | input | 1 | Host takes the oldest receive byte |
| host_rdata | output | DW | Oldest receive byte |
| rx_push | input | 1 | Deserializer delivers a byte |
| rx_pdata | input | DW | Byte from deserializer |
| tx_pop | input | 1 | Shifter takes the oldest transmit byte |
| tx_pdata | output | DW | Oldest transmit byte |
| char_timeout | input | 1 | Character-timeout pulse |
| rx_count | output | CW | Receive fill count |
| tx_count | output | CW | Transmit fill count |
| rxrdy_n | output | 1 | Receive DMA request, active low |
| txrdy_n | output | 1 | Transmit DMA request, active low |
| rx_int | output | 1 | Received-data-available interrupt |
| tx_int | output | 1 | Transmit interrupt |

## Verification
The bench sweeps every fill count from empty to full and back, for all four trigger selects in each direction. A design that released the mode-1 request at the trigger instead of at empty (or at full for transmit) would show the request line toggling in the middle of a drain. An off-by-one comparison, such as at-or-above where strictly-above is required, shows up at exactly one count. The bench pushes into a full queue and into a full single-byte holding register, and confirms the stored byte survives; a design that wrapped its pointer would corrupt the order. The clear bits are exercised one at a time, again on a later write to show they do not persist, and with FIFO mode off. A design that cleared the wrong queue, latched the bit, or acted with FIFO mode off would show a changed count.

// File: rtl/uart_fifo_dma_ctl.sv
module uart_fifo_dma_ctl #(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fcr_we,
  input  logic [7:0]    fcr_wdata,
  input  logic          rx_int_en,
  input  logic          tx_int_en,
  input  logic          host_wr,
  input  logic [DW-1:0] host_wdata,
  input  logic          host_rd,
  output logic [DW-1:0] host_rdata,
  input  logic          rx_push,
  input  logic [DW-1:0] rx_pdata,
  input  logic          tx_pop,
  output logic [DW-1:0] tx_pdata,
  input  logic          char_timeout,
  output logic [CW-1:0] rx_count,
  output logic [CW-1:0] tx_count,
  output logic          rxrdy_n,
  output logic          txrdy_n,
  output logic          rx_int,
  output logic          tx_int
);

  localparam logic [CW-1:0] FULL_C = CW'(DEPTH);
  localparam logic [CW-1:0] ONE_C  = CW'(1);

  logic       fifo_en, dma_sel;
  logic [1:0] rx_sel, tx_sel;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      fifo_en <= 1'b0;
      dma_sel <= 1'b0;
      rx_sel  <= 2'b00;
      tx_sel  <= 2'b00;
    end else if (fcr_we) begin
      fifo_en <= fcr_wdata[0];
      dma_sel <= fcr_wdata[3];
      tx_sel  <= fcr_wdata[5:4];
      rx_sel  <= fcr_wdata[7:6];
    end

  logic flip, clr_rx, clr_tx, burst;
  logic [CW-1:0] cap;

  assign flip   = fcr_we && (fcr_wdata[0] != fifo_en);
  assign clr_rx = fcr_we && (flip || (fcr_wdata[0] && fcr_wdata[1]));
  assign clr_tx = fcr_we && (flip || (fcr_wdata[0] && fcr_wdata[2]));
  assign burst  = fifo_en && dma_sel;
  assign cap    = fifo_en ? FULL_C : ONE_C;

  logic [CW-1:0] rx_lvl, tx_thr;

  always_comb begin
    case (rx_sel)
      2'b00:   rx_lvl = CW'(DEPTH / 8);
      2'b01:   rx_lvl = CW'(DEPTH / 4);
      2'b10:   rx_lvl = CW'(DEPTH - 8);
      default: rx_lvl = CW'(DEPTH - 4);
    endcase
    if (!fifo_en) rx_lvl = ONE_C;
    case (tx_sel)
      2'b00:   tx_thr = CW'(DEPTH / 8);
      2'b01:   tx_thr = CW'(DEPTH / 4);
      2'b10:   tx_thr = CW'(DEPTH / 2);
      default: tx_thr = CW'(DEPTH - 8);
    endcase
  end

  logic [DW-1:0] rx_mem [DEPTH];
  logic [AW-1:0] rx_wp, rx_rp;
  logic [CW-1:0] rx_cnt, rx_cnt_nx;
  logic          rx_put, rx_get;

  assign rx_put    = rx_push && (rx_cnt != cap) && !clr_rx;
  assign rx_get    = host_rd && (rx_cnt != '0) && !clr_rx;
  assign rx_cnt_nx = clr_rx ? '0 : rx_cnt + CW'(rx_put) - CW'(rx_get);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_wp  <= '0;
      rx_rp  <= '0;
      rx_cnt <= '0;
    end else begin
      rx_cnt <= rx_cnt_nx;
      if (clr_rx) begin
        rx_wp <= '0;
        rx_rp <= '0;
      end else begin
        if (rx_put) rx_wp <= rx_wp + AW'(1);
        if (rx_get) rx_rp <= rx_rp + AW'(1);
      end
    end

  always_ff @(posedge clk)
    if (rx_put) rx_mem[rx_wp] <= rx_pdata;

  logic [DW-1:0] tx_mem [DEPTH];
  logic [AW-1:0] tx_wp, tx_rp;
  logic [CW-1:0] tx_cnt, tx_cnt_nx;
  logic          tx_put, tx_get;

  assign tx_put    = host_wr && (tx_cnt != cap) && !clr_tx;
  assign tx_get    = tx_pop && (tx_cnt != '0) && !clr_tx;
  assign tx_cnt_nx = clr_tx ? '0 : tx_cnt + CW'(tx_put) - CW'(tx_get);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_wp  <= '0;
      tx_rp  <= '0;
      tx_cnt <= '0;
    end else begin
      tx_cnt <= tx_cnt_nx;
      if (clr_tx) begin
        tx_wp <= '0;
        tx_rp <= '0;
      end else begin
        if (tx_put) tx_wp <= tx_wp + AW'(1);
        if (tx_get) tx_rp <= tx_rp + AW'(1);
      end
    end

  always_ff @(posedge clk)
    if (tx_put) tx_mem[tx_wp] <= host_wdata;

  logic rx_req, tx_req;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_req <= 1'b0;
      tx_req <= 1'b1;
    end else begin
      rx_req <= (rx_cnt_nx == '0) ? 1'b0 : (rx_req || rx_cnt_nx >= rx_lvl || char_timeout);
      tx_req <= (tx_cnt_nx == FULL_C) ? 1'b0 : (tx_req || (FULL_C - tx_cnt_nx) > tx_thr);
    end

  assign host_rdata = rx_mem[rx_rp];
  assign tx_pdata   = tx_mem[tx_rp];
  assign rx_count   = rx_cnt;
  assign tx_count   = tx_cnt;
  assign rxrdy_n    = burst ? !rx_req : (rx_cnt == '0);
  assign txrdy_n    = burst ? !tx_req : (tx_cnt != '0);
  assign rx_int     = rx_int_en && (rx_cnt >= rx_lvl);
  assign tx_int     = tx_int_en && (fifo_en ? ((cap - tx_cnt) > tx_thr) : (tx_cnt == '0));

  p_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count <= cap) && (tx_count <= cap));

  p_rx_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!burst && !fcr_we && rx_push && !host_rd) |=> !rxrdy_n);

  p_tx_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!burst && !fcr_we && host_wr && !tx_pop) |=> txrdy_n);

  p_rx_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (burst && !fcr_we && !rxrdy_n) |=> (!rxrdy_n || rx_count == '0));

  p_tx_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (burst && !fcr_we && !txrdy_n) |=> (!txrdy_n || tx_count == FULL_C));

  p_tx_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fcr_we && fifo_en && fcr_wdata[0] && fcr_wdata[2] && !fcr_wdata[1] && !rx_push && !host_rd)
      |=> (tx_count == '0) && $stable(rx_count));

  p_rx_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (fcr_we && fifo_en && fcr_wdata[0] && fcr_wdata[1] && !fcr_wdata[2] && !host_wr && !tx_pop)
      |=> (rx_count == '0) && $stable(tx_count));

  p_no_shrink_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (!fcr_we && !host_rd) |=> rx_count >= $past(rx_count));

  p_flip_r14: assert property (@(posedge clk) disable iff (!rst_n)
    (fcr_we && fcr_wdata[0] != fifo_en) |=> (rx_count == '0) && (tx_count == '0));

endmodule

// File: tb/uart_fifo_dma_ctl_test.sv
`timescale 1ns/1ps
module uart_fifo_dma_ctl_test;
  localparam int DEPTH = 64;
  localparam int DW = 8;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 0, rst_n = 0;
  logic fcr_we = 0, rx_int_en = 0, tx_int_en = 0;
  logic [7:0] fcr_wdata = 0;
  logic host_wr = 0, host_rd = 0, rx_push = 0, tx_pop = 0, char_timeout = 0;
  logic [DW-1:0] host_wdata = 0, rx_pdata = 0, host_rdata, tx_pdata;
  logic [CW-1:0] rx_count, tx_count;
  logic rxrdy_n, txrdy_n, rx_int, tx_int;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  uart_fifo_dma_ctl #(.DEPTH(DEPTH), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .fcr_we(fcr_we), .fcr_wdata(fcr_wdata),
    .rx_int_en(rx_int_en), .tx_int_en(tx_int_en),
    .host_wr(host_wr), .host_wdata(host_wdata), .host_rd(host_rd), .host_rdata(host_rdata),
    .rx_push(rx_push), .rx_pdata(rx_pdata), .tx_pop(tx_pop), .tx_pdata(tx_pdata),
    .char_timeout(char_timeout), .rx_count(rx_count), .tx_count(tx_count),
    .rxrdy_n(rxrdy_n), .txrdy_n(txrdy_n), .rx_int(rx_int), .tx_int(tx_int));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    fcr_we = 0; host_wr = 0; host_rd = 0; rx_push = 0; tx_pop = 0; char_timeout = 0;
  endtask

  task automatic fcr(input logic [7:0] v);
    fcr_we = 1; fcr_wdata = v; tick();
  endtask
  task automatic rxpush(input int d);
    rx_push = 1; rx_pdata = 8'(d); tick();
  endtask
  task automatic rxpop();
    host_rd = 1; tick();
  endtask
  task automatic txwrite(input int d);
    host_wr = 1; host_wdata = 8'(d); tick();
  endtask
  task automatic txpop();
    tx_pop = 1; tick();
  endtask

  function automatic int rxl(input int s);
    case (s) 0: return 8; 1: return 16; 2: return 56; default: return 60; endcase
  endfunction
  function automatic int txt(input int s);
    case (s) 0: return 8; 1: return 16; 2: return 32; default: return 56; endcase
  endfunction

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int lvl;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    tick();
    chk("R1 rx_count", int'(rx_count), 0);
    chk("R1 tx_count", int'(tx_count), 0);
    chk("R1 rxrdy_n", int'(rxrdy_n), 1);
    chk("R1 txrdy_n", int'(txrdy_n), 0);
    chk("R1 rx_int", int'(rx_int), 0);
    chk("R1 tx_int", int'(tx_int), 0);
    rx_int_en = 1; tx_int_en = 1;

    // non-FIFO mode with DMA bit set: R2 R3 R4 R12
    fcr(8'h08);
    rxpush(8'h5A);
    chk("R3 rxrdy_n held", int'(rxrdy_n), 0);
    chk("R7 rx_int level 1", int'(rx_int), 1);
    rxpush(8'h33);
    chk("R2 rx cap 1", int'(rx_count), 1);
    chk("R2 rx byte kept", int'(host_rdata), 8'h5A);
    rxpop();
    chk("R12 rxrdy_n empty", int'(rxrdy_n), 1);
    chk("R8 tx_int empty", int'(tx_int), 1);
    txwrite(8'h11);
    chk("R4 txrdy_n held", int'(txrdy_n), 1);
    chk("R8 tx_int busy", int'(tx_int), 0);
    txwrite(8'h22);
    chk("R2 tx cap 1", int'(tx_count), 1);
    chk("R2 tx byte kept", int'(tx_pdata), 8'h11);
    fcr(8'h04);
    chk("R10 no clear when FIFO off", int'(tx_count), 1);
    txpop();
    chk("R12 txrdy_n empty", int'(txrdy_n), 0);

    // FIFO mode, DMA mode 0: R3 R13 R7 default level
    fcr(8'h01);
    for (int n = 1; n <= DEPTH; n++) begin
      rxpush(n);
      chk("R3 rxrdy_n fill", int'(rxrdy_n), 0);
      chk("R7 rx_int default", int'(rx_int), n >= 8 ? 1 : 0);
    end
    rxpush(200);
    chk("R2 rx full drop", int'(rx_count), DEPTH);
    for (int n = 1; n <= DEPTH; n++) begin
      chk("R13 rx order", int'(host_rdata), n);
      rxpop();
      chk("R3 rxrdy_n drain", int'(rxrdy_n), n == DEPTH ? 1 : 0);
    end
    for (int n = 1; n <= DEPTH; n++) begin
      txwrite(n + 100);
      chk("R4 txrdy_n fill", int'(txrdy_n), 1);
    end
    for (int n = 1; n <= DEPTH; n++) begin
      chk("R13 tx order", int'(tx_pdata), n + 100);
      txpop();
      chk("R4 txrdy_n drain", int'(txrdy_n), n == DEPTH ? 0 : 1);
    end

    // DMA mode 1 receive sweep: R5 R7
    for (int s = 0; s < 4; s++) begin
      fcr(8'(8'h09 | (s << 6)));
      lvl = rxl(s);
      for (int n = 1; n <= DEPTH; n++) begin
        rxpush(n);
        chk("R5 rxrdy_n fill", int'(rxrdy_n), n >= lvl ? 0 : 1);
        chk("R7 rx_int fill", int'(rx_int), n >= lvl ? 1 : 0);
      end
      for (int n = DEPTH - 1; n >= 0; n--) begin
        rxpop();
        chk("R5 rxrdy_n drain", int'(rxrdy_n), n == 0 ? 1 : 0);
        chk("R7 rx_int drain", int'(rx_int), n >= lvl ? 1 : 0);
      end
    end

    // timeout path: R5
    fcr(8'h09);
    char_timeout = 1; tick();
    chk("R5 timeout empty", int'(rxrdy_n), 1);
    for (int n = 0; n < 3; n++) rxpush(n);
    chk("R5 below trigger", int'(rxrdy_n), 1);
    char_timeout = 1; tick();
    chk("R5 timeout raises", int'(rxrdy_n), 0);
    rxpop(); rxpop();
    chk("R5 timeout hold", int'(rxrdy_n), 0);
    rxpop();
    chk("R5 timeout release", int'(rxrdy_n), 1);

    // interrupt gate: R9
    rx_int_en = 0;
    for (int n = 0; n < 10; n++) rxpush(n);
    chk("R9 rx_int gated", int'(rx_int), 0);
    rx_int_en = 1;
    #1 chk("R9 rx_int ungated", int'(rx_int), 1);
    fcr(8'h0B);
    chk("R11 rx cleared", int'(rx_count), 0);

    // DMA mode 1 transmit sweep: R6 R8
    for (int s = 0; s < 4; s++) begin
      fcr(8'(8'h09 | (s << 4)));
      lvl = txt(s);
      chk("R6 txrdy_n empty", int'(txrdy_n), 0);
      for (int n = 1; n <= DEPTH; n++) begin
        txwrite(n);
        chk("R6 txrdy_n fill", int'(txrdy_n), n == DEPTH ? 1 : 0);
        chk("R8 tx_int fill", int'(tx_int), (DEPTH - n) > lvl ? 1 : 0);
      end
      txwrite(0);
      chk("R2 tx full drop", int'(tx_count), DEPTH);
      for (int n = DEPTH - 1; n >= 0; n--) begin
        txpop();
        chk("R6 txrdy_n drain", int'(txrdy_n), (DEPTH - n) > lvl ? 0 : 1);
        chk("R8 tx_int drain", int'(tx_int), (DEPTH - n) > lvl ? 1 : 0);
      end
    end

    // clear bits: R10 R11 R14
    fcr(8'h01);
    for (int n = 0; n < 5; n++) begin rxpush(n); txwrite(n + 40); end
    fcr(8'h05);
    chk("R10 tx cleared", int'(tx_count), 0);
    chk("R10 rx kept", int'(rx_count), 5);
    chk("R10 txrdy_n after clear", int'(txrdy_n), 0);
    txwrite(8'hAA); txwrite(8'hBB);
    chk("R10 first after clear", int'(tx_pdata), 8'hAA);
    fcr(8'h01);
    chk("R10 not retained", int'(tx_count), 2);
    fcr(8'h03);
    chk("R11 rx cleared", int'(rx_count), 0);
    chk("R11 tx kept", int'(tx_count), 2);
    rxpush(9);
    fcr(8'h01);
    chk("R11 not retained", int'(rx_count), 1);
    fcr(8'h00);
    chk("R14 rx flushed", int'(rx_count), 0);
    chk("R14 tx flushed", int'(tx_count), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule